// File: doc/BRIEF.md
# Host-Ingress Command Tag Parser

This block sits on the receive side of the switch port that faces a host CPU. Every frame the host sends carries a four-byte command tag right after the destination and source MAC addresses (byte offsets 12 to 15). The tag is a forwarding command, not a VLAN. The block reads it and turns it into sideband directives: a destination port mask, a flag that says whether VLAN rules must be applied, and the VID to use for forwarding. It then removes those four bytes from the byte stream, so the tag never leaves any egress port.

To decode the tag, the block first collects the first twenty bytes of the frame. That span holds the addresses, the command tag and a possible ordinary VLAN tag behind it. Once the directives are known, the buffered bytes are replayed without the tag. After that, the rest of the frame flows straight from input to output with ready passed through. The input length is counted against a limit, and an oversize frame is marked with an error flag that comes out alongside its end marker.

When VLAN rules are requested, the forwarding VID comes from an ordinary VLAN tag that directly follows the command tag. The command tag's own VID bits are never used as the forwarding VID. A separate flag reports a frame that would be treated as priority-tagged and addressed only to port 0, when the host port is configured to admit only VLAN-tagged frames.

Top module: `host_cmd_tag_parser`

## Requirements
- R1: Bytes 12 to 15 of every frame are dropped from the output. All other bytes leave in their input order, and the output start marker is set on the first output byte only.
- R2: When bit 6 of the command tag's VID is 0, the VLAN-rules flag is 0 and the VID output is 0. The VID field is 12 bits: byte 14 bits 3:0 are VID bits 11:8, and byte 15 holds VID bits 7:0.
- R3: When VID bit 6 is 1 and bytes 16 and 17 are 0x81 and 0x00, the VLAN-rules flag is 1. The VID output is then the 12-bit value in byte 18 bits 3:0 (high part) and byte 19 (low part), and those four bytes still pass to the output.
- R4: When VID bit 6 is 1 but bytes 16 and 17 are not 0x81 0x00, or the frame has fewer than 20 bytes, the VID output is 0.
- R5: The destination port mask equals VID bits 2:0 of the command tag, with bit n standing for port n.
- R6: With the jumbo input low, a frame longer than 1522 input bytes has the error output set on its last output byte, and a frame of 1522 bytes or fewer does not.
- R7: With the jumbo input high, the input limit is 2048 bytes instead of 1522.
- R8: A frame of fewer than 16 input bytes has the error output set on its last output byte.
- R9: The priority-filter output is 1 exactly when the admit-only-VLAN input is 1, the port mask is 001, and VID bits 11:3 of the command tag are all 0.
- R10: The sideband outputs are valid with the first output byte and stay unchanged until the last output byte of that frame.
- R11: The error output is never set except together with the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_jumbo | input | 1 | Raises the input length limit to 2048 bytes |
| cfg_admit_only_vlan | input | 1 | Host port admits only VLAN-tagged frames |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of a frame |
| out_eof | output | 1 | Last output byte of a frame |
| out_err | output | 1 | Frame too long or too short, set with out_eof |
| sb_dst_mask | output | 3 | Destination port mask |
| sb_vlan_rules | output | 1 | VLAN rules apply |
| sb_vid | output | 12 | Effective forwarding VID |
| sb_prio_filter | output | 1 | Priority-tagged frame to port 0 with admit-only-VLAN set |

## Verification
The bench aims at the edges of the twenty-byte header window:

- **Exactly twenty bytes.** A frame ending at byte 20 must take its end marker from the replay buffer. A design that mishandles this hangs, or emits a stray byte.
- **Exactly 16 and 14 bytes.** These sit at the short-frame boundary. A design that gets it wrong either flags a valid frame or misses a truncated tag.
- **Look-alike second tag.** A second tag with the wrong TPID must leave the VID at zero. A design that gets it wrong forwards on a bogus VID.
- **Lengths 1522, 1523 and 2049, with and without jumbo.** An off-by-one in the counter shows up as the error flag on the wrong frame.

A design that lost the VID bit 6 decision would report rules or a VID on frames that should get the all-ports default. Random output stalls check that the sideband holds steady while bytes wait.

// File: rtl/hct_pkg.sv
// Shared constants and types for the host-ingress command tag parser.
// Assumes byte offsets counted from the first byte of the frame.
package hct_pkg;
    localparam int unsigned HDR_LEN   = 20;  // bytes collected before decoding
    localparam int unsigned TAG_OFS   = 12;  // first command tag byte
    localparam int unsigned TAG_LEN   = 4;   // command tag length
    localparam int unsigned N_PORTS   = 3;
    localparam int unsigned VID_W     = 12;
    localparam int unsigned HCNT_W    = $clog2(HDR_LEN + 1);

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_REPLAY  = 2'd1,
        ST_STREAM  = 2'd2
    } hct_state_e;

    typedef struct packed {
        logic [N_PORTS-1:0] dst;
        logic               rules;
        logic [VID_W-1:0]   vid;
        logic               prio_filt;
    } hct_side_t;
endpackage

// File: rtl/hct_tag_decode.sv
// Decodes the command tag and an optional following VLAN tag from the
// buffered header. Purely combinational. Assumes hdr_cnt is the number of
// valid header bytes; bytes at or beyond hdr_cnt are stale and not trusted.
module hct_tag_decode
    import hct_pkg::*;
(
    input  logic [HDR_LEN-1:0][7:0] hdr,
    input  logic [HCNT_W-1:0]       hdr_cnt,
    input  logic                    admit_only,
    output hct_side_t               side
);
    localparam int unsigned VID_HI = TAG_OFS + 2;
    localparam int unsigned VID_LO = TAG_OFS + 3;
    localparam int unsigned IN_TP  = TAG_OFS + TAG_LEN;

    logic [VID_W-1:0] cmd_vid;
    logic             inner_tag;

    // form the command VID and spot an inner 0x8100 tag
    always_comb begin
        cmd_vid   = {hdr[VID_HI][3:0], hdr[VID_LO]};
        inner_tag = (hdr_cnt == HCNT_W'(HDR_LEN)) && (hdr[IN_TP] == 8'h81)
                    && (hdr[IN_TP+1] == 8'h00);
    end

    // build the sideband directives
    always_comb begin
        side.dst       = cmd_vid[N_PORTS-1:0];
        side.rules     = cmd_vid[6];
        side.vid       = (cmd_vid[6] && inner_tag) ?
                         {hdr[IN_TP+2][3:0], hdr[IN_TP+3]} : '0;
        side.prio_filt = admit_only && (cmd_vid[N_PORTS-1:0] == 3'b001)
                         && (cmd_vid[VID_W-1:3] == '0);
    end
endmodule

// File: rtl/hct_len_guard.sv
// Counts accepted input bytes of the current frame and reports when the
// current or an earlier byte of the frame lies beyond the length limit.
// Assumes cfg_jumbo is static during a frame.
module hct_len_guard #(
    parameter int unsigned LIM_STD   = 1522,
    parameter int unsigned LIM_JUMBO = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_jumbo,
    input  logic acc,
    input  logic last,
    output logic over
);
    localparam int unsigned LW = $clog2(LIM_JUMBO + 2);

    logic [LW-1:0] cnt_q;
    logic          sticky_q;
    logic [LW-1:0] limit;

    // current limit and over-length decision for the byte on the input
    always_comb begin
        limit = cfg_jumbo ? LW'(LIM_JUMBO) : LW'(LIM_STD);
        over  = sticky_q || (cnt_q >= limit);
    end

    // byte counter and sticky overflow flag, cleared at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sticky_q <= 1'b0;
        end else if (acc) begin
            if (last) begin
                cnt_q    <= '0;
                sticky_q <= 1'b0;
            end else begin
                if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                sticky_q <= over;
            end
        end
    end

    // R6
    sticky_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && over && !last) |=> over)
        else $error("length overflow not held");
endmodule

// File: rtl/host_cmd_tag_parser.sv
// Host-ingress command tag parser. Buffers the first HDR_LEN bytes, decodes
// the command tag, replays the header without it, then streams the rest.
// Assumes in_sof marks the first byte and in_eof the last byte of each frame.
module host_cmd_tag_parser
    import hct_pkg::*;
#(
    parameter int unsigned LIM_STD   = 1522,
    parameter int unsigned LIM_JUMBO = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_jumbo,
    input  logic              cfg_admit_only_vlan,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic [N_PORTS-1:0] sb_dst_mask,
    output logic              sb_vlan_rules,
    output logic [VID_W-1:0]  sb_vid,
    output logic              sb_prio_filter
);
    localparam int unsigned SKIP_TO = TAG_OFS + TAG_LEN;

    hct_state_e               st_q;
    logic [HDR_LEN-1:0][7:0]  hdr_q;
    logic [HCNT_W-1:0]        wr_q, rd_q, rd_nxt, wr_idx;
    logic                     ended_q, final_b, short_b, in_acc, out_acc, over;
    hct_side_t                side;

    hct_tag_decode u_dec (
        .hdr(hdr_q), .hdr_cnt(wr_q), .admit_only(cfg_admit_only_vlan), .side(side)
    );

    hct_len_guard #(.LIM_STD(LIM_STD), .LIM_JUMBO(LIM_JUMBO)) u_len (
        .clk(clk), .rst_n(rst_n), .cfg_jumbo(cfg_jumbo),
        .acc(in_acc), .last(in_eof), .over(over)
    );

    // sideband is decoded from the held header
    always_comb begin
        sb_dst_mask    = side.dst;
        sb_vlan_rules  = side.rules;
        sb_vid         = side.vid;
        sb_prio_filter = side.prio_filt;
    end

    // replay index stepping over the command tag
    always_comb begin
        rd_nxt  = (rd_q == HCNT_W'(TAG_OFS - 1)) ? HCNT_W'(SKIP_TO) : rd_q + 1'b1;
        final_b = rd_nxt >= wr_q;
        short_b = wr_q < HCNT_W'(SKIP_TO);
        wr_idx  = in_sof ? '0 : wr_q;
    end

    // stream steering per state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        out_err   = 1'b0;
        case (st_q)
            ST_COLLECT: in_ready = 1'b1;
            ST_REPLAY: begin
                out_valid = 1'b1;
                out_data  = hdr_q[rd_q];
                out_sof   = (rd_q == '0);
                out_eof   = ended_q && final_b;
                out_err   = ended_q && final_b && short_b;
            end
            ST_STREAM: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_eof   = in_eof;
                out_err   = in_eof && over;
            end
            default: ;
        endcase
        in_acc  = in_valid && in_ready;
        out_acc = out_valid && out_ready;
    end

    // state, header buffer and indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_COLLECT;
            hdr_q   <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            ended_q <= 1'b0;
        end else begin
            case (st_q)
                ST_COLLECT: if (in_acc) begin
                    hdr_q[wr_idx] <= in_data;
                    wr_q          <= wr_idx + 1'b1;
                    rd_q          <= '0;
                    ended_q       <= in_eof;
                    if (in_eof || (wr_idx == HCNT_W'(HDR_LEN - 1)))
                        st_q <= ST_REPLAY;
                end
                ST_REPLAY: if (out_acc) begin
                    if (final_b) begin
                        if (ended_q) begin
                            st_q <= ST_COLLECT;
                            wr_q <= '0;
                        end else begin
                            st_q <= ST_STREAM;
                        end
                    end else begin
                        rd_q <= rd_nxt;
                    end
                end
                ST_STREAM: if (in_acc && in_eof) begin
                    st_q <= ST_COLLECT;
                    wr_q <= '0;
                end
                default: st_q <= ST_COLLECT;
            endcase
        end
    end

    // R1
    tag_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REPLAY && out_acc && rd_q == HCNT_W'(TAG_OFS - 1) && !final_b)
        |=> (rd_q == HCNT_W'(SKIP_TO)))
        else $error("command tag bytes not skipped");

    // R2
    no_rules_vid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sb_vlan_rules) |-> (sb_vid == '0))
        else $error("VID reported without VLAN rules");

    // R9
    prio_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_prio_filter |-> (sb_dst_mask == 3'b001 && cfg_admit_only_vlan))
        else $error("priority filter for wrong mask");

    // R10
    side_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eof)
        |=> ($stable(sb_vid) && $stable(sb_dst_mask) && $stable(sb_vlan_rules)))
        else $error("sideband changed inside a frame");

    // R11
    err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> out_eof)
        else $error("error flag away from end marker");
endmodule

// File: tb/host_cmd_tag_parser_test.sv
module host_cmd_tag_parser_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed { logic [7:0] d; logic last; logic err; } item_t;
    typedef struct packed { logic [2:0] dst; logic rules; logic [11:0] vid; logic filt; logic chk; } sbx_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_jumbo = 1'b0, cfg_admit = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, out_ready = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic in_ready, out_valid, out_sof, out_eof, out_err, sb_rules, sb_filt;
    logic [7:0] out_data;
    logic [2:0] sb_dst;
    logic [11:0] sb_vid;

    int checks = 0, errors = 0;
    bit done = 1'b0, mid = 1'b0;
    item_t exp_q[$];
    sbx_t  sb_q[$];
    logic [7:0] fb[$];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_cmd_tag_parser uut (
        .clk(clk), .rst_n(rst_n), .cfg_jumbo(cfg_jumbo), .cfg_admit_only_vlan(cfg_admit),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err), .sb_dst_mask(sb_dst),
        .sb_vlan_rules(sb_rules), .sb_vid(sb_vid), .sb_prio_filter(sb_filt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // downstream stall pattern
    always @(posedge clk) begin
        #1;
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready <= (lfsr[2:0] != 3'b000);
    end

    // monitor: pop expected bytes and sideband
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected byte", 32'(out_data), 32'hFFFF);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(out_data == e.d, "R1 data", 32'(out_data), 32'(e.d));
                chk(out_eof == e.last, "R1 end marker", 32'(out_eof), 32'(e.last));
                chk(out_err == e.err, "R6/R7/R8/R11 error flag", 32'(out_err), 32'(e.err));
                chk(out_sof == !mid, "R1 start marker", 32'(out_sof), 32'(!mid));
                if (!mid) begin
                    sbx_t s;
                    s = sb_q.pop_front();
                    if (s.chk) begin
                        chk(sb_dst == s.dst, "R5 port mask", 32'(sb_dst), 32'(s.dst));
                        chk(sb_rules == s.rules, "R2/R3 rules flag", 32'(sb_rules), 32'(s.rules));
                        chk(sb_vid == s.vid, "R3/R4 VID", 32'(sb_vid), 32'(s.vid));
                        chk(sb_filt == s.filt, "R9 priority filter", 32'(sb_filt), 32'(s.filt));
                    end
                end
                mid = !out_eof;
            end
        end
    end

    // build a frame of n bytes with the given command tag and bytes 16..19
    task automatic make(input int n, input logic [7:0] t14, input logic [7:0] t15,
                        input logic [31:0] inner);
        fb.delete();
        for (int i = 0; i < n; i++) fb.push_back(8'((i * 7 + n) & 8'hFF));
        if (n > 14) fb[14] = t14;
        if (n > 15) fb[15] = t15;
        for (int k = 0; k < 4; k++) if (n > 16 + k) fb[16 + k] = inner[31 - 8*k -: 8];
    endtask

    // driver: push expectations, then drive the frame
    task automatic run(input bit admit, input bit jumbo);
        int n, lim;
        bit err;
        sbx_t s;
        logic [11:0] cv;
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
        cfg_admit = admit;
        cfg_jumbo = jumbo;
        n   = fb.size();
        lim = jumbo ? 2048 : 1522;
        err = (n < 16) || (n > lim);
        cv  = (n >= 16) ? {fb[14][3:0], fb[15]} : 12'h000;
        s.chk   = (n >= 16);
        s.dst   = cv[2:0];
        s.rules = cv[6];
        s.vid   = (cv[6] && n >= 20 && fb[16] == 8'h81 && fb[17] == 8'h00) ? {fb[18][3:0], fb[19]} : 12'h000;
        s.filt  = admit && cv[2:0] == 3'b001 && cv[11:3] == 9'h000;
        sb_q.push_back(s);
        for (int i = 0; i < n; i++) begin
            if (i < 12 || i > 15) exp_q.push_back({fb[i], 1'b0, 1'b0});
        end
        exp_q[exp_q.size() - 1] = {exp_q[exp_q.size() - 1].d, 1'b1, err};
        for (int i = 0; i < n; i++) begin
            bit acc;
            in_valid = 1'b1;
            in_data  = fb[i];
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            do begin @(negedge clk); acc = in_ready; end while (!acc);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 1);
        make(64, 8'h00, 8'h06, 32'h81002ABC); run(1'b0, 1'b0);   // R2 R5: rules off, ports 1,2
        make(64, 8'h00, 8'h42, 32'h81002ABC); run(1'b0, 1'b0);   // R3: inner tag gives VID
        make(60, 8'h00, 8'h44, 32'h08004500); run(1'b0, 1'b0);   // R4: no inner tag
        make(60, 8'h00, 8'h41, 32'h88A80123); run(1'b0, 1'b0);   // R4: wrong inner TPID
        make(20, 8'h00, 8'h43, 32'h8100A555); run(1'b0, 1'b0);   // R3: exactly 20 bytes
        make(19, 8'h00, 8'h43, 32'h8100A555); run(1'b0, 1'b0);   // R4: too short for inner tag
        make(40, 8'h00, 8'h01, 32'h08000000); run(1'b1, 1'b0);   // R9: filter set
        make(40, 8'h01, 8'h01, 32'h08000000); run(1'b1, 1'b0);   // R9: unused VID bit set
        make(40, 8'h00, 8'h01, 32'h08000000); run(1'b0, 1'b0);   // R9: admit-only off
        make(40, 8'h00, 8'h03, 32'h08000000); run(1'b1, 1'b0);   // R9: two ports
        make(14, 8'h00, 8'h00, 32'h0);         run(1'b0, 1'b0);   // R8: short frame
        make(16, 8'h00, 8'h02, 32'h0);         run(1'b0, 1'b0);   // R8: 16 bytes ok
        make(1522, 8'h00, 8'h05, 32'h08000000); run(1'b0, 1'b0); // R6: at limit
        make(1523, 8'h00, 8'h05, 32'h08000000); run(1'b0, 1'b0); // R6: one over
        make(1523, 8'h00, 8'h05, 32'h08000000); run(1'b0, 1'b1); // R7: jumbo allows
        make(2049, 8'h00, 8'h05, 32'h08000000); run(1'b0, 1'b1); // R7: over jumbo
        make(64, 8'h00, 8'h47, 32'h8100F00D); run(1'b0, 1'b0);   // R10 R11: recovery
        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(sb_q.size() == 0, "R10 sideband count", 32'(sb_q.size()), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: R1 stream stalled actual=%0d expected=0", exp_q.size());
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule